// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers sixteen interrupt request lines. A rising edge on an enabled line marks that source pending. While any pending source is also unmasked, the block pulls its active-low request output low. The processor answers with an acknowledge cycle by asserting the acknowledge strobe and the data strobe together. The block then places an 8-bit vector on its data outputs and completes the handshake with an active-low transfer acknowledge. The vector joins a programmable upper nibble with the number of the highest-priority unmasked pending source. Source 15 has the highest priority and source 0 the lowest.

Several of these blocks can share one request level and one acknowledge line through a chain input and a chain output, both active low. The first device in the chain has its chain input tied low. Each later device takes its chain input from the chain output of the device above it. A device answers an acknowledge cycle only if its chain input is low and it holds an unmasked pending request when the cycle starts. In every other case it leaves the bus and the acknowledge line released.

The bus drivers appear as value/enable pairs, so the surrounding pads build the three-state buffers. All inputs are synchronous to `clk`.

Top module: `irq_vec_chain`

## Requirements
- R1: A source becomes pending on a clock in which its input is high, was low on the previous clock, and its enable bit is 1. An edge on a source whose enable bit is 0 leaves nothing pending.
- R2: `irq_n` is 0 exactly when at least one pending source has its mask bit at 1. A pending source with mask bit 0 stays pending, and it raises `irq_n` low once it is unmasked.
- R3: The vector is {`vbase_i`, i}, with `vbase_i` in bits 7..4 and i in bits 3..0. Here i is the highest-numbered pending, unmasked source.
- R4: In the first clock edge where `iack_n`=0, `ds_n`=0 and the device may respond, the device moves into a data phase. In that phase `d_oe`=1 and `dtack_oe`=1, with `dtack_n`=1. On the next edge `dtack_n` goes to 0 while the vector stays driven.
- R5: On the first edge at which `iack_n` or `ds_n` is seen high, the device releases the data bus (`d_oe`=0) and drives `dtack_n`=1 for one clock. On the edge after that, `dtack_oe` goes to 0.
- R6: The device responds only if `iei_n`=0 and it holds a pending unmasked source at the edge where the cycle begins. If it does not respond at that edge, it leaves `d_oe` and `dtack_oe` at 0 until both strobes have been seen high again. This holds even if `iei_n` falls during that cycle.
- R7: `ieo_n` is 0 exactly when `iei_n`=0, no pending unmasked source exists, and the device is not serving an acknowledge cycle.
- R8: When the vector is captured, the pending bit of the serviced source clears. If a new enabled edge on that source arrives on the same clock, the bit stays pending.
- R9: The driven vector does not change during a cycle, even when a higher-priority request arrives in the middle of it.
- R10: After reset nothing is pending, `irq_n`=1, `d_oe`=0, `dtack_oe`=0 and `dtack_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Interrupt request lines, edge-sensitive |
| ena_i | input | 16 | Per-source edge enable |
| msk_i | input | 16 | Per-source mask, 1 lets a pending source request |
| vbase_i | input | 4 | Upper nibble of the vector |
| iack_n | input | 1 | Acknowledge strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| iei_n | input | 1 | Chain input, low when no device above is requesting |
| irq_n | output | 1 | Interrupt request, active low |
| ieo_n | output | 1 | Chain output to the next lower device |
| d_o | output | 8 | Vector value |
| d_oe | output | 1 | Drive enable for `d_o` |
| dtack_n | output | 1 | Transfer acknowledge value, active low |
| dtack_oe | output | 1 | Drive enable for `dtack_n` |

## Verification
Two events can land on the same clock edge: the vector capture that clears the serviced pending bit, and a new edge on that same source. The bench provokes this by raising a source that is already pending on the same clock that the acknowledge strobes fall. After the cycle it expects `irq_n` still low, and it expects a second acknowledge to return that same source number. A second collision puts a higher-priority request in the middle of the data phase. The bench judges it by watching the driven vector stay unchanged, then expecting the new source's vector in the next cycle.

// File: rtl/irq_vec_chain.sv
module irq_vec_chain #(
  parameter int NSRC = 16,
  parameter int VW   = 8,
  localparam int IW  = $clog2(NSRC),
  localparam int BW  = VW - IW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] ena_i,
  input  logic [NSRC-1:0] msk_i,
  input  logic [BW-1:0]   vbase_i,
  input  logic            iack_n,
  input  logic            ds_n,
  input  logic            iei_n,
  output logic            irq_n,
  output logic            ieo_n,
  output logic [VW-1:0]   d_o,
  output logic            d_oe,
  output logic            dtack_n,
  output logic            dtack_oe
);

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_ACK, S_END, S_PASS} st_t;

  st_t             st;
  logic [NSRC-1:0] src_q, pend, act, clr, rise;
  logic [IW-1:0]   win;
  logic [VW-1:0]   vec;
  logic            cyc, any_act, start, busy;

  assign cyc     = ~iack_n & ~ds_n;
  assign rise    = src_i & ~src_q & ena_i;
  assign act     = pend & msk_i;
  assign any_act = |act;
  assign start   = (st == S_IDLE) & cyc & ~iei_n & any_act;
  assign clr     = start ? (NSRC'(1) << win) : '0;
  assign busy    = (st == S_DATA) | (st == S_ACK) | (st == S_END);

  always_comb begin
    win = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i]) win = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
      vec   <= '0;
    end else begin
      src_q <= src_i;
      pend  <= (pend & ~clr) | rise;
      if (start) vec <= {vbase_i, win};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else
      case (st)
        S_IDLE:  if (cyc) st <= start ? S_DATA : S_PASS;
        S_DATA:  st <= cyc ? S_ACK : S_END;
        S_ACK:   if (!cyc) st <= S_END;
        S_END:   st <= S_IDLE;
        S_PASS:  if (iack_n && ds_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

  assign irq_n    = ~any_act;
  assign ieo_n    = iei_n | any_act | busy;
  assign d_o      = vec;
  assign d_oe     = (st == S_DATA) | (st == S_ACK);
  assign dtack_oe = busy;
  assign dtack_n  = (st != S_ACK);

endmodule

// File: rtl/irq_vec_chain_chk.sv
module irq_vec_chain_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iei_n,
  input logic          irq_n,
  input logic          ieo_n,
  input logic [VW-1:0] d_o,
  input logic          d_oe,
  input logic          dtack_n,
  input logic          dtack_oe
);

  a_r4_data_before_dtack: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && !dtack_n) |-> ($past(d_oe) && d_oe));

  a_r9_vector_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && $past(d_oe)) |-> $stable(d_o));

  a_r6_drive_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_oe) |-> $past(!iei_n && !irq_n));

  a_r5_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack_oe && !d_oe) |=> !dtack_oe);

  a_r5_dtack_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_oe) |-> $past(dtack_n));

  a_r7_ieo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ieo_n |-> (!iei_n && irq_n && !dtack_oe));

endmodule

bind irq_vec_chain irq_vec_chain_chk #(.VW(VW)) u_chk (.*);

// File: tb/irq_vec_chain_tb.sv
`timescale 1ns/1ps
module irq_vec_chain_tb;

  logic        clk = 0, rst_n = 0;
  logic [15:0] src_i = '0, ena_i = '1, msk_i = '1;
  logic [3:0]  vbase_i = 4'hA;
  logic        iack_n = 1, ds_n = 1, iei_n = 0;
  logic        irq_n, ieo_n, d_oe, dtack_n, dtack_oe;
  logic [7:0]  d_o;
  int          runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_vec_chain u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_i[s] = 1;
    @(negedge clk); src_i[s] = 0;
    nclk(1);
  endtask

  task automatic ack(input logic [7:0] exp);
    @(negedge clk); iack_n = 0; ds_n = 0;
    nclk(1);
    chk("R4 data phase d_oe", d_oe, 1);
    chk("R4 data phase dtack_n", {dtack_oe, dtack_n}, 2'b11);
    chk("R3 vector", d_o, exp);
    nclk(1);
    chk("R4 dtack asserted", {d_oe, dtack_oe, dtack_n}, 3'b110);
    chk("R9 vector held", d_o, exp);
    ds_n = 1;
    nclk(1);
    chk("R5 end drives high", {d_oe, dtack_oe, dtack_n}, 3'b011);
    iack_n = 1;
    nclk(1);
    chk("R5 released", dtack_oe, 0);
  endtask

  task automatic t_reset;
    chk("R10 irq_n", irq_n, 1);
    chk("R10 outputs", {d_oe, dtack_oe, dtack_n}, 3'b001);
  endtask

  task automatic t_priority;
    pulse(2); pulse(9); pulse(14);
    chk("R2 irq low", irq_n, 0);
    ack(8'hAE); ack(8'hA9);
    chk("R2 still pending", irq_n, 0);
    ack(8'hA2);
    chk("R8 all cleared", irq_n, 1);
  endtask

  task automatic t_disabled;
    ena_i[7] = 0; pulse(7);
    chk("R1 disabled edge ignored", irq_n, 1);
    ena_i[7] = 1; nclk(2);
    chk("R1 no late pending", irq_n, 1);
    pulse(7);
    chk("R1 enabled edge pends", irq_n, 0);
    ack(8'hA7);
  endtask

  task automatic t_mask;
    msk_i[4] = 0; pulse(4);
    chk("R2 masked no irq", irq_n, 1);
    chk("R7 masked ieo low", ieo_n, 0);
    @(negedge clk); msk_i[4] = 1; #1;
    chk("R2 unmask raises irq", irq_n, 0);
    chk("R7 ieo high on request", ieo_n, 1);
    ack(8'hA4);
  endtask

  task automatic t_chain;
    pulse(6);
    @(negedge clk); iei_n = 1; #1;
    chk("R7 upstream blocks ieo", ieo_n, 1);
    iack_n = 0; ds_n = 0;
    nclk(2);
    chk("R6 blocked no drive", {d_oe, dtack_oe}, 2'b00);
    iei_n = 0;
    nclk(3);
    chk("R6 no late answer", {d_oe, dtack_oe}, 2'b00);
    iack_n = 1; ds_n = 1;
    nclk(2);
    ack(8'hA6);
  endtask

  task automatic t_service_ieo;
    pulse(1);
    @(negedge clk); iack_n = 0; ds_n = 0;
    nclk(1);
    chk("R7 ieo held in service", ieo_n, 1);
    ds_n = 1; iack_n = 1;
    nclk(2);
    chk("R7 ieo low after service", ieo_n, 0);
  endtask

  task automatic t_race;
    vbase_i = 4'h3;
    pulse(5);
    @(negedge clk); iack_n = 0; ds_n = 0; src_i[5] = 1;
    nclk(1);
    chk("R3 race vector", d_o, 8'h35);
    src_i[5] = 0; ds_n = 1; iack_n = 1;
    nclk(2);
    chk("R8 new edge keeps pending", irq_n, 0);
    ack(8'h35);
    chk("R8 cleared afterwards", irq_n, 1);
  endtask

  task automatic t_frozen;
    pulse(3);
    @(negedge clk); iack_n = 0; ds_n = 0;
    nclk(1);
    src_i[12] = 1;
    nclk(1);
    src_i[12] = 0;
    nclk(1);
    chk("R9 vector frozen", d_o, 8'h33);
    ds_n = 1; iack_n = 1;
    nclk(2);
    chk("R9 later request pending", irq_n, 0);
    ack(8'h3C);
    chk("R2 idle again", irq_n, 1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    nclk(2);
    t_reset();
    rst_n = 1;
    nclk(2);
    t_priority();
    t_disabled();
    t_mask();
    t_chain();
    t_service_ieo();
    t_race();
    t_frozen();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule